// File: doc/BRIEF.md
# Video DRAM Refresh-Mode Sequencer

This block sits on the controller side of a multiport video DRAM. It drives the memory's active-low strobe pins and its special-function pin, and issues only refresh cycles in which the column strobe falls before the row strobe. The memory uses its own internal row counter, so the sequencer places no address. There are three cycle flavours. A plain refresh holds the write strobe high and the special-function pin low. A stop-register refresh holds the write strobe low and the special-function pin high, which puts the serial register into stop mode. A mask-keeping refresh holds both low, which leaves the persistent write mask intact.

After reset the sequencer runs a burst of `INIT_CNT` plain refreshes (eight by default). After that it issues one plain refresh for every vertical-retrace pulse. When the configuration asks for one, a mode cycle follows each plain refresh. The stop-register flavour wins when it is enabled. Otherwise the mask-keeping flavour is used when persistent masking is enabled. The configured stop address is range-checked: a value above 127 breaks compatibility between half-depth and full-depth serial-register operation, and the sequencer raises an error flag for it.

The states are `ST_IDLE`, `ST_SETUP`, `ST_ROWLO` and `ST_PRECH`. In `ST_SETUP` the column strobe is low and the row strobe is high. In `ST_ROWLO` both strobes are low. In `ST_PRECH` all strobes are high. The transitions are:
- **idle→setup** when a mode cycle is owed (first priority), init cycles remain (second), or a retrace is pending (third).
- **setup→rowlo**, **rowlo→prech** and **prech→idle**, each when the phase timer expires.

Top module: `vram_refresh_seq`

## Requirements
- R1: While reset is held and on the first clock after release, row, column and write strobes are high, the special-function pin is low and busy is high.
- R2: In every cycle the column strobe is low for exactly `T_SETUP` (2) clocks before the row strobe falls, and the row strobe is never low unless the column strobe is low.
- R3: The row strobe stays low for exactly `T_ROW` (4) clocks. Before the next column-strobe fall, all strobes stay high for at least `T_PRE` (3) clocks.
- R4: After reset, `INIT_CNT` (8) plain refresh cycles are issued with no retrace input. Busy stays high until they are finished and then drops when nothing else is owed.
- R5: A plain refresh holds the write strobe high (1) and the special-function pin low (0) while the column strobe is low.
- R6: When `cfg_stop_en` is 1, every plain refresh is followed directly by a stop-register refresh: write strobe 0, special-function pin 1.
- R7: When `cfg_stop_en` is 0 and `cfg_keep_mask_en` is 1, every plain refresh is followed directly by a mask-keeping refresh: write strobe 0, special-function pin 0. When both enables are 0, no mode cycle follows.
- R8: Once initialisation is over, each isolated retrace pulse produces exactly one plain refresh.
- R9: A retrace pulse that arrives while a cycle runs is held pending and served afterwards. A pulse in the same clock in which a pending retrace is taken produces one further plain refresh.
- R10: `stop_addr_err` is high one clock after `cfg_stop_en` is 1 and `cfg_stop_addr` exceeds 127, and low one clock after any other combination.
- R11: Whenever busy is low, the row, column and write strobes are high and the special-function pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retrace | input | 1 | Vertical-retrace pulse, one or more clocks high |
| cfg_stop_en | input | 1 | Follow each plain refresh with a stop-register refresh |
| cfg_keep_mask_en | input | 1 | Follow each plain refresh with a mask-keeping refresh (when stop is off) |
| cfg_stop_addr | input | ADDR_W | Configured serial stop address, range-checked |
| row_strb_n | output | 1 | Active-low row strobe |
| col_strb_n | output | 1 | Active-low column strobe |
| wr_strb_n | output | 1 | Active-low write strobe |
| spec_fn | output | 1 | Special-function pin |
| busy | output | 1 | A cycle is running or owed |
| stop_addr_err | output | 1 | Stop address out of range while stop mode is enabled |

## Verification
Arrival of a retrace pulse and consumption of the pending retrace by the idle state can fall in the same clock. A pending flag that clears there without also latching the new pulse would lose a frame's refresh. The bench provokes this with a two-clock retrace pulse from idle: the first clock sets the pending flag, and the second clock coincides with the idle state taking it. The bench judges the case by counting the plain refresh cycles decoded from the pins, which must be two, and it separately checks a pulse that lands in the middle of a running cycle.

// File: rtl/vram_refresh_pkg.sv
package vram_refresh_pkg;

    typedef enum logic [1:0] {
        FLV_PLAIN = 2'd0,
        FLV_STOP  = 2'd1,
        FLV_KEEP  = 2'd2
    } flavor_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ROWLO = 2'd2,
        ST_PRECH = 2'd3
    } seq_state_t;

endpackage

// File: rtl/vram_refresh_timer.sv
module vram_refresh_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = (cnt == '0);

    // Timer rests at zero until reloaded (phase lengths, R3)
    assert_timer_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/vram_refresh_latch.sv
module vram_refresh_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic retrace,
    input  logic take,
    output logic pending
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (retrace) begin
            pending <= 1'b1;
        end else if (take) begin
            pending <= 1'b0;
        end
    end

    // A retrace is never lost, even when it meets a take
    assert_retrace_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        retrace |=> pending);

endmodule

// File: rtl/vram_refresh_decode.sv
module vram_refresh_decode
    import vram_refresh_pkg::*;
(
    input  seq_state_t state,
    input  flavor_t    flv,
    output logic       row_n,
    output logic       col_n,
    output logic       wr_n,
    output logic       sf
);

    logic active;

    always_comb begin
        active = (state == ST_SETUP) || (state == ST_ROWLO);
        col_n  = !active;
        row_n  = (state != ST_ROWLO);
        wr_n   = !(active && (flv != FLV_PLAIN));
        sf     = active && (flv == FLV_STOP);
    end

endmodule

// File: rtl/vram_refresh_seq.sv
module vram_refresh_seq
    import vram_refresh_pkg::*;
#(
    parameter int T_SETUP  = 2,
    parameter int T_ROW    = 4,
    parameter int T_PRE    = 3,
    parameter int INIT_CNT = 8,
    parameter int ADDR_W   = 9,
    parameter int STOP_MAX = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retrace,
    input  logic              cfg_stop_en,
    input  logic              cfg_keep_mask_en,
    input  logic [ADDR_W-1:0] cfg_stop_addr,
    output logic              row_strb_n,
    output logic              col_strb_n,
    output logic              wr_strb_n,
    output logic              spec_fn,
    output logic              busy,
    output logic              stop_addr_err
);

    localparam int LEN_A   = (T_SETUP > T_ROW) ? T_SETUP : T_ROW;
    localparam int LEN_MAX = (LEN_A > T_PRE) ? LEN_A : T_PRE;
    localparam int CW      = $clog2(LEN_MAX + 1);
    localparam int IW      = $clog2(INIT_CNT + 1);
    localparam logic [CW-1:0] L_SETUP = CW'(T_SETUP - 1);
    localparam logic [CW-1:0] L_ROW   = CW'(T_ROW - 1);
    localparam logic [CW-1:0] L_PRE   = CW'(T_PRE - 1);
    localparam logic [ADDR_W-1:0] STOP_LIM = ADDR_W'(STOP_MAX);

    seq_state_t     state, nstate;
    flavor_t        flv, mode_flv;
    logic           need_mode;
    logic [IW-1:0]  init_left;
    logic           pending, take;
    logic           start_plain, start_mode;
    logic           expired, load;
    logic [CW-1:0]  load_val;

    // ---------------- next-state logic ----------------
    always_comb begin
        nstate      = state;
        take        = 1'b0;
        start_plain = 1'b0;
        start_mode  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (need_mode) begin
                    nstate     = ST_SETUP;
                    start_mode = 1'b1;
                end else if (init_left != '0) begin
                    nstate      = ST_SETUP;
                    start_plain = 1'b1;
                end else if (pending) begin
                    nstate      = ST_SETUP;
                    start_plain = 1'b1;
                    take        = 1'b1;
                end
            end
            ST_SETUP: if (expired) nstate = ST_ROWLO;
            ST_ROWLO: if (expired) nstate = ST_PRECH;
            ST_PRECH: if (expired) nstate = ST_IDLE;
        endcase
    end

    always_comb begin
        load = (nstate != state);
        unique case (nstate)
            ST_SETUP: load_val = L_SETUP;
            ST_ROWLO: load_val = L_ROW;
            ST_PRECH: load_val = L_PRE;
            ST_IDLE:  load_val = '0;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            flv       <= FLV_PLAIN;
            mode_flv  <= FLV_STOP;
            need_mode <= 1'b0;
            init_left <= IW'(INIT_CNT);
        end else begin
            state <= nstate;
            if (start_plain) begin
                flv       <= FLV_PLAIN;
                need_mode <= cfg_stop_en || cfg_keep_mask_en;
                mode_flv  <= cfg_stop_en ? FLV_STOP : FLV_KEEP;
                if (init_left != '0) init_left <= init_left - IW'(1);
            end else if (start_mode) begin
                flv       <= mode_flv;
                need_mode <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stop_addr_err <= 1'b0;
        else        stop_addr_err <= cfg_stop_en && (cfg_stop_addr > STOP_LIM);
    end

    // ---------------- sub-blocks ----------------
    vram_refresh_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
    );

    vram_refresh_latch u_latch (
        .clk(clk), .rst_n(rst_n), .retrace(retrace), .take(take), .pending(pending)
    );

    // ---------------- output process ----------------
    vram_refresh_decode u_dec (
        .state(state), .flv(flv),
        .row_n(row_strb_n), .col_n(col_strb_n), .wr_n(wr_strb_n), .sf(spec_fn)
    );

    always_comb begin
        busy = (state != ST_IDLE) || (init_left != '0) || need_mode || pending;
    end

    // ---------------- assertions ----------------
    logic [CW+1:0] rowlo_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           rowlo_run <= '0;
        else if (!row_strb_n) rowlo_run <= rowlo_run + (CW+2)'(1);
        else                  rowlo_run <= '0;
    end

    assert_row_needs_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !row_strb_n |-> !col_strb_n);

    assert_col_before_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_strb_n) |-> $past(!col_strb_n));

    assert_row_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_strb_n) |-> (rowlo_run == (CW+2)'(T_ROW)));

    assert_sf_with_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spec_fn |-> (!wr_strb_n && !col_strb_n));

    assert_idle_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (row_strb_n && col_strb_n && wr_strb_n && !spec_fn));

    assert_stop_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stop_en && cfg_stop_addr > STOP_LIM) |=> stop_addr_err);

    assert_stop_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_stop_en && cfg_stop_addr > STOP_LIM) |=> !stop_addr_err);

endmodule

// File: tb/vram_refresh_seq_test.sv
`timescale 1ns/1ps
module vram_refresh_seq_test;

    localparam int ADDR_W = 9;
    localparam int K_PLAIN = 0, K_STOP = 1, K_KEEP = 2, K_BAD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic retrace = 1'b0;
    logic cfg_stop_en = 1'b0;
    logic cfg_keep_mask_en = 1'b0;
    logic [ADDR_W-1:0] cfg_stop_addr = '0;
    logic row_strb_n, col_strb_n, wr_strb_n, spec_fn, busy, stop_addr_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    vram_refresh_seq uut (
        .clk(clk), .rst_n(rst_n), .retrace(retrace),
        .cfg_stop_en(cfg_stop_en), .cfg_keep_mask_en(cfg_keep_mask_en),
        .cfg_stop_addr(cfg_stop_addr),
        .row_strb_n(row_strb_n), .col_strb_n(col_strb_n), .wr_strb_n(wr_strb_n),
        .spec_fn(spec_fn), .busy(busy), .stop_addr_err(stop_addr_err)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic int exp_mode(input bit stop_en, input bit keep_en);
        if (stop_en) return K_STOP;
        if (keep_en) return K_KEEP;
        return -1;
    endfunction

    function automatic bit exp_err(input bit stop_en, input int addr);
        return stop_en && (addr > 127);
    endfunction

    // -------- pin monitor: decodes refresh cycles --------
    int kinds [0:1023];
    int nlog = 0;
    int setup_cnt = 0, row_cnt = 0, gap_cnt = 0;
    bit in_gap = 0, prev_col = 1, prev_row = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_col && !col_strb_n) begin
                if (nlog < 1024) begin
                    if (wr_strb_n && !spec_fn)       kinds[nlog] = K_PLAIN;
                    else if (!wr_strb_n && spec_fn)  kinds[nlog] = K_STOP;
                    else if (!wr_strb_n && !spec_fn) kinds[nlog] = K_KEEP;
                    else                              kinds[nlog] = K_BAD;
                end
                nlog++;
                if (in_gap) chk(gap_cnt >= 3, "R3", "precharge clocks", gap_cnt, 3);
                in_gap = 0;
                setup_cnt = 1;
            end else if (!col_strb_n && row_strb_n) begin
                setup_cnt++;
            end
            if (!row_strb_n && col_strb_n) chk(0, "R2", "row low without col", 0, 1);
            if (prev_row && !row_strb_n) begin
                chk(setup_cnt == 2, "R2", "col-to-row setup clocks", setup_cnt, 2);
                row_cnt = 1;
            end else if (!row_strb_n) begin
                row_cnt++;
            end
            if (!prev_row && row_strb_n) begin
                chk(row_cnt == 4, "R3", "row low clocks", row_cnt, 4);
                in_gap = 1;
                gap_cnt = 1;
            end else if (in_gap && row_strb_n && col_strb_n) begin
                gap_cnt++;
            end
            prev_col = col_strb_n;
            prev_row = row_strb_n;
        end
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    task automatic pulse(input int width);
        @(negedge clk) retrace = 1'b1;
        repeat (width - 1) @(negedge clk);
        @(negedge clk) retrace = 1'b0;
    endtask

    task automatic settle(input string rq);
        int n;
        n = 0;
        repeat (2) @(negedge clk);
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, rq, "busy cleared", busy, 0);
        chk(row_strb_n && col_strb_n && wr_strb_n && !spec_fn, "R11",
            "idle pins while not busy", {row_strb_n, col_strb_n, wr_strb_n, spec_fn}, 4'b1110);
    endtask

    task automatic check_seq(input string rq, input int base, input int exp_n,
                             input int e0, input int e1);
        chk(nlog - base == exp_n, rq, "cycle count", nlog - base, exp_n);
        if (nlog - base >= 1) chk(kinds[base] == e0, rq, "first cycle kind", kinds[base], e0);
        if (exp_n >= 2 && nlog - base >= 2)
            chk(kinds[base+1] == e1, rq, "second cycle kind", kinds[base+1], e1);
    endtask

    task automatic run_retrace(input bit s, input bit k, input string rq);
        int base, m;
        cfg_stop_en = s;
        cfg_keep_mask_en = k;
        base = nlog;
        pulse(1);
        settle(rq);
        m = exp_mode(s, k);
        if (m < 0) check_seq(rq, base, 1, K_PLAIN, K_PLAIN);
        else       check_seq(rq, base, 2, K_PLAIN, m);
    endtask

    initial begin
        int base;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk(row_strb_n && col_strb_n && wr_strb_n && !spec_fn && busy, "R1",
            "pins during reset", {row_strb_n, col_strb_n, wr_strb_n, spec_fn, busy}, 5'b11101);
        rst_n = 1'b1;
        chk(row_strb_n && col_strb_n && wr_strb_n && !spec_fn && busy, "R1",
            "pins after release", {row_strb_n, col_strb_n, wr_strb_n, spec_fn, busy}, 5'b11101);

        // R4: init burst of 8 plain cycles, busy throughout
        repeat (20) @(negedge clk);
        chk(busy, "R4", "busy during init", busy, 1);
        settle("R4");
        chk(nlog == 8, "R4", "init cycle count", nlog, 8);
        for (int i = 0; i < 8; i++) chk(kinds[i] == K_PLAIN, "R5", "init cycle plain", kinds[i], K_PLAIN);

        // directed flavour cases
        cfg_stop_addr = 9'd100;
        run_retrace(1'b1, 1'b0, "R6");
        run_retrace(1'b0, 1'b1, "R7");
        run_retrace(1'b1, 1'b1, "R6");
        run_retrace(1'b0, 1'b0, "R8");

        // R9: retrace during a running cycle
        cfg_stop_en = 0; cfg_keep_mask_en = 0;
        base = nlog;
        pulse(1);
        repeat (5) @(negedge clk);
        pulse(1);
        settle("R9");
        check_seq("R9", base, 2, K_PLAIN, K_PLAIN);

        // R9: retrace in the same clock the pending one is taken
        base = nlog;
        pulse(2);
        settle("R9");
        check_seq("R9", base, 2, K_PLAIN, K_PLAIN);

        // R10: stop address boundary
        cfg_stop_en = 1; cfg_stop_addr = 9'd128;
        repeat (2) @(negedge clk);
        chk(stop_addr_err == 1'b1, "R10", "addr 128", stop_addr_err, 1);
        cfg_stop_addr = 9'd127;
        repeat (2) @(negedge clk);
        chk(stop_addr_err == 1'b0, "R10", "addr 127", stop_addr_err, 0);
        cfg_stop_en = 0; cfg_stop_addr = 9'd300;
        repeat (2) @(negedge clk);
        chk(stop_addr_err == 1'b0, "R10", "stop disabled", stop_addr_err, 0);

        // constrained random
        for (int it = 0; it < 25; it++) begin
            bit s, k;
            int a;
            s = 1'($urandom % 2);
            k = 1'($urandom % 2);
            a = int'($urandom % 512);
            cfg_stop_addr = ADDR_W'(a);
            cfg_stop_en = s;
            repeat (2) @(negedge clk);
            chk(stop_addr_err == exp_err(s, a), "R10", "random addr", stop_addr_err, exp_err(s, a));
            repeat (int'($urandom % 20)) @(negedge clk);
            run_retrace(s, k, (exp_mode(s, k) == K_STOP) ? "R6" :
                              (exp_mode(s, k) == K_KEEP) ? "R7" : "R8");
        end

        report();
    end

endmodule